// File: doc/BRIEF.md
# Load Address and Data Alignment Unit

This unit executes byte, half-word and word loads for a 32-bit core. A load arrives with a base register value, a 16-bit displacement, an access size and a destination register index. The unit adds the sign-extended displacement to the base to form the effective address. It issues one word-aligned read to memory over a valid/ready handshake. When the data word returns, the unit picks the addressed lane out of it, sign-extends it and presents a 32-bit result with the destination index.

A misaligned address does not raise a fault. The low address bits that the access size cannot use are dropped without notice. Memory is a 32-bit little-endian port, and the unit allows only one load in flight at a time.

Top module: `load_align_unit`

## Requirements
- R1: The read address on `mem_addr_o` is (base + sign-extended 16-bit displacement) modulo 2^32 with bits 1:0 forced to zero.
- R2: Size code 2'b00 (byte) returns the byte at lane ea[1:0] of the response word, where lane 0 is bits 7:0 and lane 3 is bits 31:24, sign-extended to 32 bits.
- R3: Size code 2'b01 (half-word) ignores ea[0]. It returns bits 15:0 when ea[1] is 0 and bits 31:16 when ea[1] is 1, sign-extended to 32 bits.
- R4: Size code 2'b10 (word) ignores ea[1:0] and returns the response word unchanged. Code 2'b11 behaves the same way.
- R5: `res_dst_o` carries the destination index that was given with the accepted request.
- R6: `req_ready_o` is high only while no load is in flight. A request presented while it is low is ignored.
- R7: `mem_req_valid_o` stays high with a stable address until `mem_req_ready_i` is seen high. After that, the unit waits for `mem_rsp_valid_i`.
- R8: `res_valid_o` goes high for exactly one cycle, in the cycle after the response is taken.
- R9: After reset, `req_ready_o` is 1 and `mem_req_valid_o` and `res_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Unit can take a load |
| req_base_i | input | 32 | Base register value |
| req_disp_i | input | 16 | Signed displacement |
| req_size_i | input | 2 | Access size code |
| req_dst_i | input | 5 | Destination register index |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts read request |
| mem_addr_o | output | 32 | Word-aligned read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data word |
| res_valid_o | output | 1 | Result valid pulse |
| res_dst_o | output | 5 | Result destination index |
| res_data_o | output | 32 | Sign-extended result |

## Verification
The bench drives every byte lane and both half-word lanes. It uses memory words with the lane's top bit both set and clear, which separates correct sign extension from zero extension or a wrong lane. Odd and misaligned word addresses show whether the unit masks the low bits. Negative displacements and bases near the top of the address space show whether the address wraps. Random loads with varied request and response latencies, along with requests presented while the unit is busy, test the one-in-flight rule and the one-cycle result pulse against a behavioural model on every clock.

// File: rtl/load_pkg.sv
package load_pkg;
  typedef enum logic [1:0] {
    LS_BYTE = 2'b00,
    LS_HALF = 2'b01,
    LS_WORD = 2'b10
  } ld_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } ld_state_e;
endpackage

// File: rtl/load_addr_gen.sv
module load_addr_gen
  import load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  ld_size_e          size_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [1:0]        lane_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] ea;

  // modulo 2^ADDR_W wrap comes from the fixed width
  assign ea          = base_i + {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign word_addr_o = {ea[ADDR_W-1:2], 2'b00};

  always_comb begin
    unique case (size_i)
      LS_BYTE: lane_o = ea[1:0];
      LS_HALF: lane_o = {ea[1], 1'b0};
      default: lane_o = 2'b00;
    endcase
  end
endmodule

// File: rtl/load_extract.sv
module load_extract
  import load_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        lane_i,
  input  ld_size_e          size_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] byte_sel;
  logic [HALF_W-1:0] half_sel;

  assign byte_sel = word_i[lane_i*BYTE_W +: BYTE_W];
  assign half_sel = word_i[lane_i[1]*HALF_W +: HALF_W];

  always_comb begin
    unique case (size_i)
      LS_BYTE: data_o = {{(DATA_W-BYTE_W){byte_sel[BYTE_W-1]}}, byte_sel};
      LS_HALF: data_o = {{(DATA_W-HALF_W){half_sel[HALF_W-1]}}, half_sel};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
  import load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_lane_i,
  input  ld_size_e          acc_size_i,
  input  logic [IDX_W-1:0]  acc_dst_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic [1:0]        lane_q_o,
  output ld_size_e          size_q_o,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              res_valid_o,
  output logic [IDX_W-1:0]  res_dst_o,
  output logic [DATA_W-1:0] res_data_o
);
  ld_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  dst_q;
  logic              accept, rsp_take;

  assign req_ready_o     = (state_q == ST_IDLE);
  assign accept          = req_ready_o && req_valid_i;
  assign rsp_take        = (state_q == ST_WAIT) && mem_rsp_valid_i;
  assign mem_req_valid_o = (state_q == ST_ISSUE);
  assign mem_addr_o      = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      lane_q_o    <= '0;
      size_q_o    <= LS_WORD;
      dst_q       <= '0;
      res_valid_o <= 1'b0;
      res_dst_o   <= '0;
      res_data_o  <= '0;
    end else begin
      res_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_ISSUE;
          addr_q   <= acc_addr_i;
          lane_q_o <= acc_lane_i;
          size_q_o <= acc_size_i;
          dst_q    <= acc_dst_i;
        end
        ST_ISSUE: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          state_q     <= ST_IDLE;
          res_valid_o <= 1'b1;
          res_dst_o   <= dst_q;
          res_data_o  <= ext_data_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

  a_r1_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_addr_o[1:0] == 2'b00));

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  a_r8_pulse_follows_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> $past(mem_rsp_valid_i));
endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import load_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [DISP_W-1:0] req_disp_i,
  input  logic [1:0]        req_size_i,
  input  logic [IDX_W-1:0]  req_dst_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              res_valid_o,
  output logic [IDX_W-1:0]  res_dst_o,
  output logic [DATA_W-1:0] res_data_o
);
  ld_size_e          in_size, size_q;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        acc_lane, lane_q;
  logic [DATA_W-1:0] ext_data;

  assign in_size = ld_size_e'(req_size_i);

  load_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .base_i      (req_base_i),
    .disp_i      (req_disp_i),
    .size_i      (in_size),
    .word_addr_o (acc_addr),
    .lane_o      (acc_lane)
  );

  load_extract #(.DATA_W(DATA_W)) u_ext (
    .word_i (mem_rsp_data_i),
    .lane_i (lane_q),
    .size_i (size_q),
    .data_o (ext_data)
  );

  load_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .acc_addr_i      (acc_addr),
    .acc_lane_i      (acc_lane),
    .acc_size_i      (in_size),
    .acc_dst_i       (req_dst_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .lane_q_o        (lane_q),
    .size_q_o        (size_q),
    .ext_data_i      (ext_data),
    .res_valid_o     (res_valid_o),
    .res_dst_o       (res_dst_o),
    .res_data_o      (res_data_o)
  );

  a_r4_word_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && !req_ready_o && !mem_req_valid_o && size_q != LS_BYTE
     && size_q != LS_HALF) |=> (res_data_o == $past(mem_rsp_data_i)));
endmodule

// File: tb/sim_load_align_unit.sv
`timescale 1ns/1ps
module sim_load_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [1:0]  req_size = '0;
  logic [4:0]  req_dst = '0;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        req_ready, mem_req_valid, res_valid;
  logic [31:0] mem_addr, res_data;
  logic [4:0]  res_dst;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint exp_at = -1;
  logic [31:0] exp_data;
  logic [4:0]  exp_dst;
  string       exp_tag;
  bit          done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  load_align_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_base_i(req_base), .req_disp_i(req_disp), .req_size_i(req_size), .req_dst_i(req_dst),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_addr_o(mem_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .res_valid_o(res_valid), .res_dst_o(res_dst), .res_data_o(res_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A0F_C3A6;
  endfunction

  // behavioural model of the result
  function automatic logic [31:0] model(input logic [31:0] ea, input logic [1:0] sz,
                                        input logic [31:0] w);
    int sh;
    logic [31:0] v;
    if (sz == 2'b00) begin
      sh = 8 * int'(ea[1:0]);
      v = (w >> sh) & 32'hFF;
      return v[7] ? (v | 32'hFFFF_FF00) : v;
    end else if (sz == 2'b01) begin
      sh = ea[1] ? 16 : 0;
      v = (w >> sh) & 32'hFFFF;
      return v[15] ? (v | 32'hFFFF_0000) : v;
    end
    return w;
  endfunction

  // per-clock comparison of result port
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cyc == exp_at) begin
        check({exp_tag, " R8 valid"}, {31'd0, res_valid}, 32'd1);
        check({exp_tag, " data"}, res_data, exp_data);
        check("R5 dst", {27'd0, res_dst}, {27'd0, exp_dst});
      end else if (res_valid !== 1'b0) begin
        check("R8 stray pulse", {31'd0, res_valid}, 32'd0);
      end
    end
  end

  task automatic do_load(input logic [31:0] base, input logic [15:0] disp,
                         input logic [1:0] sz, input logic [4:0] dst,
                         input int req_lat, input int rsp_lat, input logic [31:0] word_ovr,
                         input bit use_ovr);
    logic [31:0] ea, wa, w;
    ea = base + {{16{disp[15]}}, disp};
    wa = {ea[31:2], 2'b00};
    check("R6 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1; req_base = base; req_disp = disp; req_size = sz; req_dst = dst;
    @(negedge clk);
    req_valid = 0; req_base = ~base; req_dst = ~dst;
    check("R1 mem_addr", mem_addr, wa);
    check("R7 req valid", {31'd0, mem_req_valid}, 32'd1);
    for (int i = 0; i < req_lat; i++) begin
      req_valid = 1; // ignored while busy
      @(negedge clk);
      check("R7 held", {31'd0, mem_req_valid}, 32'd1);
      check("R7 addr stable", mem_addr, wa);
      check("R6 busy", {31'd0, req_ready}, 32'd0);
    end
    req_valid = 0;
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    check("R7 dropped", {31'd0, mem_req_valid}, 32'd0);
    for (int i = 0; i < rsp_lat; i++) begin
      req_valid = 1; req_dst = 5'h1F;
      @(negedge clk);
      check("R6 busy wait", {31'd0, req_ready}, 32'd0);
    end
    req_valid = 0;
    w = use_ovr ? word_ovr : mem_word(wa);
    mem_rsp_valid = 1; mem_rsp_data = w;
    exp_data = model(ea, sz, w);
    exp_dst = dst;
    exp_tag = (sz == 2'b00) ? "R2" : (sz == 2'b01) ? "R3" : "R4";
    exp_at = cyc + 1;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = 32'hDEAD_BEEF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 ready", {31'd0, req_ready}, 32'd1);
    check("R9 memreq", {31'd0, mem_req_valid}, 32'd0);
    check("R9 resvalid", {31'd0, res_valid}, 32'd0);
    // byte lanes, sign set/clear
    for (int l = 0; l < 4; l++) begin
      do_load(32'h0000_1000, 16'(l), 2'b00, 5'(l + 1), 0, 0, 32'h80_7F_FF_01, 1);
      do_load(32'h0000_1000, 16'(l), 2'b00, 5'(l + 9), 1, 1, 32'h7F_80_01_FF, 1);
    end
    // half lanes, odd addresses masked (R3)
    do_load(32'h2000, 16'h0001, 2'b01, 5'd3, 0, 2, 32'h1234_8765, 1);
    do_load(32'h2000, 16'h0003, 2'b01, 5'd4, 2, 0, 32'h9ABC_4321, 1);
    do_load(32'h2000, 16'h0002, 2'b01, 5'd5, 0, 0, 32'h7FFF_0000, 1);
    // word with misaligned address (R4), size 11
    do_load(32'h3003, 16'h0000, 2'b10, 5'd6, 1, 0, 32'hCAFE_F00D, 1);
    do_load(32'h3001, 16'h0002, 2'b11, 5'd7, 0, 1, 32'h8000_0001, 1);
    // negative displacement and wrap (R1)
    do_load(32'h0000_0000, 16'hFFFC, 2'b10, 5'd8, 0, 0, 32'h0, 0);
    do_load(32'hFFFF_FFF0, 16'h0021, 2'b00, 5'd30, 0, 0, 32'h0, 0);
    do_load(32'h8000_0000, 16'h8000, 2'b01, 5'd31, 1, 1, 32'h0, 0);
    // random sweep
    for (int k = 0; k < 60; k++)
      do_load($urandom, 16'($urandom), 2'($urandom % 4), 5'($urandom),
              int'($urandom % 3), int'($urandom % 3), 32'h0, 0);
    // stray response while idle is ignored (R8)
    mem_rsp_valid = 1;
    @(negedge clk);
    mem_rsp_valid = 0;
    repeat (2) @(negedge clk);
    check("R9 idle after", {31'd0, req_ready}, 32'd1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule